// File: doc/BRIEF.md
# SSE and YMM State Restore Sequencer

This block performs the restore half of extended-state management for the 128-bit vector registers, the upper halves of the 256-bit vector registers and the vector control/status word. It reads from a save area in memory through a simple read port of 16-byte words. For each of the two components it then either loads register values from the save area or writes the processor's init value of zero. A pulse on `start` carries a two-bit request mask. Bit 0 of `req_mask` requests the 128-bit vector state and bit 1 requests the upper-half state. `mode64` selects how many registers are involved.

Before it commits anything, the sequencer fetches the control/status word and all four header words. It checks reserved fields and keeps the header's state bitmap. If a check fails, it reports a general-protection fault and makes no register write. Otherwise it writes the control/status word first. It then walks the 128-bit registers and then the upper halves, in ascending order. For each component the choice between load and init is the AND of the request bit and the matching bitmap bit.

Top module: `xstate_restore_seq`

## Requirements
- R1: When `req_mask` is 00, the block makes no memory read and no register write, and it does not fault. It still pulses `done`.
- R2: When `req_mask[0]` is 1 and there is no fault, bitmap bit 1 selects the action for each 128-bit register i. If the bit is 1, the register is loaded from byte 160+16*i. If the bit is 0, the register is written with zero and no read is made for it.
- R3: When `req_mask[1]` is 1 and there is no fault, bitmap bit 2 selects the action for each upper half i. If the bit is 1, the upper half is loaded from byte 576+16*i. If the bit is 0, it is written with zero and no read is made for it.
- R4: Whenever either mask bit is 1 and there is no fault, exactly one control/status write is made. Its value is the 32 bits at byte 24, whatever the bitmap holds. The control/status word never takes an init value.
- R5: With `mode64`=1, each enabled component writes registers 0 to 15. With `mode64`=0, it writes only registers 0 to 7.
- R6: If any control/status bit above bit 15 is set, `gp_fault` is raised together with `done` and no register write is made.
- R7: If any header byte from 520 to 575 is nonzero, `gp_fault` is raised together with `done` and no register write is made. All bitmap bits other than 1 and 2 are ignored.
- R8: `done` is high for exactly one cycle per request. When writes were made, it comes in the cycle right after the last write.
- R9: The memory address is a word index, equal to the byte offset divided by 16. A request holds its valid and address until it is accepted. The state bitmap is bits [63:0] of the word at byte 512.
- R10: At most one write enable is high per cycle. The order of writes is the control/status word, then the 128-bit registers in ascending index, then the upper halves in ascending index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| req_mask | input | 2 | Bit 0: 128-bit vector state, bit 1: upper-half state |
| mode64 | input | 1 | 1: sixteen registers per component, 0: eight |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_addr | output | AW (12) | Word index of the read |
| mem_rsp_valid | input | 1 | Read data valid, one cycle, at least one cycle after acceptance |
| mem_rsp_data | input | DW (128) | Read data, byte 0 in bits [7:0] |
| xmm_we | output | 1 | Write enable, 128-bit vector register |
| ymmh_we | output | 1 | Write enable, upper half register |
| mxcsr_we | output | 1 | Write enable, control/status word (value in wr_data[31:0]) |
| wr_idx | output | IW (4) | Register index of the write |
| wr_data | output | DW (128) | Write data |
| done | output | 1 | One-cycle completion pulse |
| gp_fault | output | 1 | General-protection fault, high with done |

## Verification
The embedded properties check several things on every cycle. Write enables are mutually exclusive. A register index stays below eight outside 64-bit mode. Init writes carry zero, and a control/status write has clear reserved bits. No write precedes a fault. Read requests stay stable until accepted, and `done` never lasts two cycles. Other behaviour only the bench scenarios can show: the load-versus-init choice for each combination of mask and bitmap, the exact data taken from each offset, the number of memory reads, the write ordering, and the timing of `done` relative to the last write. They also show fault detection on each reserved field and the absence of action when the mask is empty.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_DEC, S_MX, S_SEL, S_LDW, S_FIN
  } xrs_state_e;

  // 32-bit lane of a 16-byte word that holds a given byte offset
  function automatic logic [31:0] lane32(input logic [127:0] w, input int unsigned byte_off);
    return 32'(w >> ((byte_off % 16) * 8));
  endfunction

  // 64-bit lane of a 16-byte word that holds a given byte offset
  function automatic logic [63:0] lane64(input logic [127:0] w, input int unsigned byte_off);
    return 64'(w >> ((byte_off % 16) * 8));
  endfunction

  // Word index of byte (base + 16*i)
  function automatic int unsigned word_of(input int unsigned base, input int unsigned i);
    return (base + 16 * i) / 16;
  endfunction

  // Check step k: 0 is the control/status word, 1 is the first header word
  // (bitmap plus reserved upper half), 2 and up are fully reserved header words.
  function automatic logic step_bad(input int unsigned k, input logic [127:0] w,
                                    input logic [31:0] rsvd, input int unsigned mx_byte);
    if (k == 0)      return |(lane32(w, mx_byte) & rsvd);
    else if (k == 1) return |w[127:64];
    else             return |w;
  endfunction

endpackage

// File: rtl/xrs_rd_port.sv
module xrs_rd_port #(
  parameter int AW = 12,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          rd_done,
  output logic [DW-1:0] rd_data
);
  logic waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_addr      <= '0;
      waiting       <= 1'b0;
    end else begin
      if (go) begin
        mem_req_valid <= 1'b1;
        mem_addr      <= go_addr;
      end else if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
        waiting       <= 1'b1;
      end else if (waiting && mem_rsp_valid) begin
        waiting       <= 1'b0;
      end
    end
  end

  assign rd_done = waiting && mem_rsp_valid;
  assign rd_data = mem_rsp_data;

  // R9: an offered request stays put until accepted
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

endmodule

// File: rtl/xrs_hdr_check.sv
module xrs_hdr_check
  import xrs_pkg::*;
#(
  parameter int          DW         = 128,
  parameter int          CKW        = 3,
  parameter int unsigned MXCSR_BYTE = 24,
  parameter int unsigned HDR_BYTE   = 512,
  parameter logic [31:0] MXCSR_RSVD = 32'hFFFF_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           word_valid,
  input  logic [CKW-1:0] step,
  input  logic [DW-1:0]  word,
  output logic           bad,
  output logic [31:0]    mxcsr_val,
  output logic           bm_vec,
  output logic           bm_upper
);
  logic        word_bad;
  logic [63:0] bitmap;

  assign word_bad = step_bad(int'(step), word, MXCSR_RSVD, MXCSR_BYTE);
  assign bitmap   = lane64(word, HDR_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad       <= 1'b0;
      mxcsr_val <= '0;
      bm_vec    <= 1'b0;
      bm_upper  <= 1'b0;
    end else if (clear) begin
      bad       <= 1'b0;
    end else if (word_valid) begin
      bad <= bad | word_bad;
      if (step == '0) mxcsr_val <= lane32(word, MXCSR_BYTE);
      if (step == CKW'(1)) begin
        bm_vec   <= bitmap[1];
        bm_upper <= bitmap[2];
      end
    end
  end

endmodule

// File: rtl/xrs_ctrl.sv
module xrs_ctrl
  import xrs_pkg::*;
#(
  parameter int          AW         = 12,
  parameter int          DW         = 128,
  parameter int          NREG       = 16,
  parameter int          NREG_LEG   = 8,
  parameter int          CHK_N      = 5,
  parameter int unsigned MXCSR_BYTE = 24,
  parameter int unsigned XMM_BYTE   = 160,
  parameter int unsigned HDR_BYTE   = 512,
  parameter int unsigned YMM_BYTE   = 576,
  parameter logic [31:0] MXCSR_RSVD = 32'hFFFF_0000,
  localparam int IW  = $clog2(NREG),
  localparam int CKW = $clog2(CHK_N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     req_mask,
  input  logic           mode64,
  output logic           rd_go,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_done,
  input  logic [DW-1:0]  rd_data,
  output logic           chk_clear,
  output logic [CKW-1:0] chk_step,
  input  logic           chk_bad,
  input  logic [31:0]    chk_mxcsr,
  input  logic           bm_vec,
  input  logic           bm_upper,
  output logic           xmm_we,
  output logic           ymmh_we,
  output logic           mxcsr_we,
  output logic [IW-1:0]  wr_idx,
  output logic [DW-1:0]  wr_data,
  output logic           done,
  output logic           gp_fault
);
  xrs_state_e     st;
  logic [1:0]     mask_q;
  logic           m64_q;
  logic           comp;      // 0: 128-bit registers, 1: upper halves
  logic [IW-1:0]  idx;
  logic           fault_q;
  logic           wr_seen;

  logic [IW-1:0]  last_idx;
  logic           comp_en, comp_load, at_last, adv_fin;

  function automatic logic [AW-1:0] step_addr(input int unsigned k);
    if (k == 0) return AW'(word_of(MXCSR_BYTE, 0));
    else        return AW'(word_of(HDR_BYTE, k - 1));
  endfunction

  function automatic logic [AW-1:0] reg_addr(input logic c, input logic [IW-1:0] i);
    return c ? AW'(word_of(YMM_BYTE, int'(i))) : AW'(word_of(XMM_BYTE, int'(i)));
  endfunction

  assign last_idx  = m64_q ? IW'(NREG - 1) : IW'(NREG_LEG - 1);
  assign comp_en   = comp ? mask_q[1] : mask_q[0];
  assign comp_load = comp_en & (comp ? bm_upper : bm_vec);
  assign at_last   = (idx == last_idx);
  assign adv_fin   = at_last && (comp || !mask_q[1]);
  assign chk_clear = (st == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mask_q   <= '0;
      m64_q    <= 1'b0;
      comp     <= 1'b0;
      idx      <= '0;
      fault_q  <= 1'b0;
      chk_step <= '0;
      rd_go    <= 1'b0;
      rd_addr  <= '0;
      xmm_we   <= 1'b0;
      ymmh_we  <= 1'b0;
      mxcsr_we <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      gp_fault <= 1'b0;
    end else begin
      rd_go    <= 1'b0;
      xmm_we   <= 1'b0;
      ymmh_we  <= 1'b0;
      mxcsr_we <= 1'b0;
      done     <= 1'b0;
      gp_fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mask_q  <= req_mask;
          m64_q   <= mode64;
          fault_q <= 1'b0;
          if (req_mask == 2'b00) begin
            st <= S_FIN;
          end else begin
            chk_step <= '0;
            rd_go    <= 1'b1;
            rd_addr  <= step_addr(0);
            st       <= S_CHK;
          end
        end
        S_CHK: if (rd_done) begin
          if (chk_step == CKW'(CHK_N - 1)) begin
            st <= S_DEC;
          end else begin
            chk_step <= chk_step + 1'b1;
            rd_go    <= 1'b1;
            rd_addr  <= step_addr(int'(chk_step) + 1);
          end
        end
        S_DEC: begin
          if (chk_bad) begin
            fault_q <= 1'b1;
            st      <= S_FIN;
          end else begin
            st <= S_MX;
          end
        end
        S_MX: begin
          mxcsr_we <= 1'b1;
          wr_idx   <= '0;
          wr_data  <= DW'(chk_mxcsr);
          comp     <= 1'b0;
          idx      <= '0;
          st       <= S_SEL;
        end
        S_SEL: begin
          if (!comp_en) begin
            comp <= 1'b1;
            idx  <= '0;
          end else if (comp_load) begin
            rd_go   <= 1'b1;
            rd_addr <= reg_addr(comp, idx);
            st      <= S_LDW;
          end else begin
            xmm_we  <= !comp;
            ymmh_we <= comp;
            wr_idx  <= idx;
            wr_data <= '0;
            if (adv_fin) st <= S_FIN;
            else if (at_last) begin comp <= 1'b1; idx <= '0; end
            else idx <= idx + 1'b1;
          end
        end
        S_LDW: if (rd_done) begin
          xmm_we  <= !comp;
          ymmh_we <= comp;
          wr_idx  <= idx;
          wr_data <= rd_data;
          st      <= S_SEL;
          if (adv_fin) st <= S_FIN;
          else if (at_last) begin comp <= 1'b1; idx <= '0; end
          else idx <= idx + 1'b1;
        end
        S_FIN: begin
          done     <= 1'b1;
          gp_fault <= fault_q;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Tracks whether any register write happened since the request began
  always_ff @(posedge clk) begin
    if (!rst_n)                          wr_seen <= 1'b0;
    else if (chk_clear)                  wr_seen <= 1'b0;
    else if (xmm_we || ymmh_we || mxcsr_we) wr_seen <= 1'b1;
  end

  // R10: never two write enables together
  p_one_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xmm_we, ymmh_we, mxcsr_we}));

  // R5: legacy mode never touches registers 8 and above
  p_legacy_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xmm_we || ymmh_we) && !m64_q |-> wr_idx < IW'(NREG_LEG));

  // R6/R7: a fault comes with done and follows no write
  p_fault_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> done && !wr_seen);

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: committed control/status word has clear reserved bits
  p_mx_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mxcsr_we |-> (wr_data[31:0] & MXCSR_RSVD) == 32'h0);

  // R2/R3: a write not fed by a read response is an init write of zero
  p_init_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xmm_we || ymmh_we) && !$past(rd_done) |-> wr_data == '0);

endmodule

// File: rtl/xstate_restore_seq.sv
module xstate_restore_seq
  import xrs_pkg::*;
#(
  parameter int          AW         = 12,
  parameter int          DW         = 128,
  parameter int          NREG       = 16,
  parameter int          NREG_LEG   = 8,
  parameter int unsigned MXCSR_BYTE = 24,
  parameter int unsigned XMM_BYTE   = 160,
  parameter int unsigned HDR_BYTE   = 512,
  parameter int unsigned YMM_BYTE   = 576,
  parameter logic [31:0] MXCSR_RSVD = 32'hFFFF_0000,
  localparam int IW        = $clog2(NREG),
  localparam int HDR_WORDS = int'((YMM_BYTE - HDR_BYTE) / 16),
  localparam int CHK_N     = 1 + HDR_WORDS,
  localparam int CKW       = $clog2(CHK_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    req_mask,
  input  logic          mode64,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          xmm_we,
  output logic          ymmh_we,
  output logic          mxcsr_we,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic          gp_fault
);
  logic           rd_go, rd_done;
  logic [AW-1:0]  rd_addr;
  logic [DW-1:0]  rd_data;
  logic           chk_clear, chk_bad, bm_vec, bm_upper;
  logic [CKW-1:0] chk_step;
  logic [31:0]    chk_mxcsr;
  logic           chk_valid;

  assign chk_valid = rd_done && !(xmm_we || ymmh_we) && (u_ctrl.st == S_CHK);

  xrs_rd_port #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .go(rd_go), .go_addr(rd_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  xrs_hdr_check #(
    .DW(DW), .CKW(CKW), .MXCSR_BYTE(MXCSR_BYTE), .HDR_BYTE(HDR_BYTE), .MXCSR_RSVD(MXCSR_RSVD)
  ) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(chk_clear),
    .word_valid(chk_valid), .step(chk_step), .word(rd_data),
    .bad(chk_bad), .mxcsr_val(chk_mxcsr), .bm_vec(bm_vec), .bm_upper(bm_upper)
  );

  xrs_ctrl #(
    .AW(AW), .DW(DW), .NREG(NREG), .NREG_LEG(NREG_LEG), .CHK_N(CHK_N),
    .MXCSR_BYTE(MXCSR_BYTE), .XMM_BYTE(XMM_BYTE), .HDR_BYTE(HDR_BYTE),
    .YMM_BYTE(YMM_BYTE), .MXCSR_RSVD(MXCSR_RSVD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask), .mode64(mode64),
    .rd_go(rd_go), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .chk_clear(chk_clear), .chk_step(chk_step), .chk_bad(chk_bad),
    .chk_mxcsr(chk_mxcsr), .bm_vec(bm_vec), .bm_upper(bm_upper),
    .xmm_we(xmm_we), .ymmh_we(ymmh_we), .mxcsr_we(mxcsr_we),
    .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .gp_fault(gp_fault)
  );

endmodule

// File: tb/xstate_restore_seq_tb.sv
`timescale 1ns/1ps
module xstate_restore_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   req_mask = 2'b00;
  logic         mode64 = 1'b0;
  logic         mem_req_valid, mem_req_ready;
  logic [11:0]  mem_addr;
  logic         mem_rsp_valid;
  logic [127:0] mem_rsp_data;
  logic         xmm_we, ymmh_we, mxcsr_we, done, gp_fault;
  logic [3:0]   wr_idx;
  logic [127:0] wr_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  xstate_restore_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask), .mode64(mode64),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xmm_we(xmm_we), .ymmh_we(ymmh_we), .mxcsr_we(mxcsr_we),
    .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .gp_fault(gp_fault)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model (16-byte words) ----------------
  logic [127:0] mem [64];
  int  rd_cnt = 0, hs_err = 0, rcnt = 0, rdy_mode = 1;
  bit  hs_prev = 0, pv_prev = 0, rdy_prev = 0;
  logic [11:0] addr_prev = '0;

  initial begin mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; end

  always @(negedge clk) begin
    mem_rsp_valid = hs_prev;
    mem_rsp_data  = hs_prev ? ((addr_prev < 64) ? mem[addr_prev[5:0]] : '0) : '0;
    if (rst_n && pv_prev && !rdy_prev && (!mem_req_valid || mem_addr != addr_prev)) hs_err++;
    rcnt++;
    mem_req_ready = (rdy_mode == 0) ? 1'b1 : ((rcnt % 3) != 0);
    hs_prev   = rst_n && mem_req_valid && mem_req_ready;
    pv_prev   = mem_req_valid;
    rdy_prev  = mem_req_ready;
    addr_prev = mem_addr;
    if (hs_prev) rd_cnt++;
  end

  function automatic logic [127:0] pat(input int w);
    return {8'hC3, 24'(w), 32'hDEAD_0000 | 32'(w), 32'(w * 7 + 1), ~32'(w)};
  endfunction

  // ---------------- vector table ----------------
  // [6] mask bit for upper halves, [5] mask bit for 128-bit regs,
  // [4] bitmap bit 2, [3] bitmap bit 1, [2] mode64,
  // [1:0] error: 0 none, 1 reserved control bit, 2 byte 520 nonzero, 3 byte 575 nonzero
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    7'b00_11_1_00, 7'b01_01_1_00, 7'b01_00_0_00, 7'b10_10_1_00,
    7'b10_00_1_00, 7'b11_11_0_00, 7'b11_01_1_00, 7'b11_10_0_00,
    7'b11_11_1_01, 7'b01_11_1_10, 7'b00_00_1_01, 7'b10_11_0_11,
    7'b01_10_1_00
  };

  logic [127:0] xg [16];
  logic [127:0] yg [16];

  task automatic run_vec(input logic [6:0] v, input int vi);
    logic m_x, m_y, b_x, b_y, m64, flt;
    logic [1:0] err;
    logic [31:0] mxv, mx_got;
    int n, xc, yc, mc, rank, last_we, done_cyc, rd0, exp_rd;
    bit ordbad, seen_done, xok, yok, gpv;
    m_y = v[6]; m_x = v[5]; b_y = v[4]; b_x = v[3]; m64 = v[2]; err = v[1:0];
    n = m64 ? 16 : 8;
    flt = (m_x || m_y) && (err != 2'd0);
    for (int w = 0; w < 64; w++) mem[w] = pat(w);
    mxv = 32'h0000_1F80 + 32'(vi);
    if (err == 2'd1) mxv = mxv | 32'h0004_0000;
    mem[24/16][95:64] = mxv;
    mem[512/16] = {64'h0, 64'h0000_0000_0000_0081 | (64'(b_x) << 1) | (64'(b_y) << 2)};
    for (int w = 528/16; w < 576/16; w++) mem[w] = '0;
    if (err == 2'd2) mem[520/16][64] = 1'b1;
    if (err == 2'd3) mem[575/16][127] = 1'b1;
    for (int i = 0; i < 16; i++) begin xg[i] = 'x; yg[i] = 'x; end
    xc = 0; yc = 0; mc = 0; rank = 0; ordbad = 0; last_we = -1; done_cyc = -1;
    mx_got = '0; seen_done = 0; gpv = 0;
    rd0 = rd_cnt;
    @(negedge clk);
    start = 1'b1; req_mask = {m_y, m_x}; mode64 = m64;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (mxcsr_we) begin
        if (rank != 0 || mc != 0) ordbad = 1;
        mc++; mx_got = wr_data[31:0]; last_we = cyc;
      end
      if (xmm_we) begin
        if (rank > 1 || int'(wr_idx) != xc) ordbad = 1;
        rank = 1; xg[wr_idx] = wr_data; xc++; last_we = cyc;
      end
      if (ymmh_we) begin
        if (int'(wr_idx) != yc) ordbad = 1;
        rank = 2; yg[wr_idx] = wr_data; yc++; last_we = cyc;
      end
      if (int'(mxcsr_we) + int'(xmm_we) + int'(ymmh_we) > 1) ordbad = 1;
      if (done) begin seen_done = 1; done_cyc = cyc; gpv = gp_fault; break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(seen_done, "R8 done seen", 128'(seen_done), 128'd1);
    chk(!done, "R8 done one cycle", 128'(done), 128'd0);
    chk(gpv == flt, (err == 2'd1) ? "R6 fault flag" : "R7 fault flag", 128'(gpv), 128'(flt));
    repeat (2) @(negedge clk);
    exp_rd = (!m_x && !m_y) ? 0 :
             5 + ((m_x && !flt && b_x) ? n : 0) + ((m_y && !flt && b_y) ? n : 0);
    chk(rd_cnt - rd0 == exp_rd, (!m_x && !m_y) ? "R1 read count" : "R9 read count",
        128'(rd_cnt - rd0), 128'(exp_rd));
    chk(mc == ((m_x || m_y) && !flt ? 1 : 0), "R4 control write count", 128'(mc),
        128'((m_x || m_y) && !flt));
    if (mc == 1) chk(mx_got == mxv, "R4 control value", 128'(mx_got), 128'(mxv));
    chk(xc == ((m_x && !flt) ? n : 0), "R5 R2 vector write count", 128'(xc), 128'((m_x && !flt) ? n : 0));
    chk(yc == ((m_y && !flt) ? n : 0), "R5 R3 upper write count", 128'(yc), 128'((m_y && !flt) ? n : 0));
    xok = 1; yok = 1;
    for (int i = 0; i < xc && i < 16; i++)
      if (xg[i] !== (b_x ? pat((160 + 16 * i) / 16) : 128'h0)) xok = 0;
    for (int i = 0; i < yc && i < 16; i++)
      if (yg[i] !== (b_y ? pat((576 + 16 * i) / 16) : 128'h0)) yok = 0;
    if (xc > 0) chk(xok, b_x ? "R2 load data" : "R2 init zero", 128'(xok), 128'd1);
    if (yc > 0) chk(yok, b_y ? "R3 load data" : "R3 init zero", 128'(yok), 128'd1);
    chk(!ordbad, "R10 write order", 128'(ordbad), 128'd0);
    if (last_we >= 0)
      chk(done_cyc == last_we + 1, "R8 done after last write", 128'(done_cyc), 128'(last_we + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    chk({mem_req_valid, xmm_we, ymmh_we, mxcsr_we, done, gp_fault} == 6'b0,
        "R1 reset outputs", 128'({mem_req_valid, xmm_we, ymmh_we, mxcsr_we, done, gp_fault}), 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NV; v++) run_vec(VEC[v], v);
    // corner: always-ready memory, full restore in 64-bit mode
    rdy_mode = 0;
    run_vec(7'b11_11_1_00, 20);
    // corner: fault on the last reserved byte with ready always high
    run_vec(7'b11_11_1_11, 21);
    chk(hs_err == 0, "R9 request held until accepted", 128'(hs_err), 128'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule